// File: doc/BRIEF.md
# Serial ADC Host Sequencer

This block runs the host side of a serial analog-to-digital converter that offers 10 bits of magnitude plus a sign bit and an input multiplexer. The converter is driven by a chip select, a serial clock, a data-in line and a data-out line, and it reports progress on a busy status line. The controller generates the serial clock from the system clock through a programmable half-period divider. It paces each exchange against the converter's fixed cycle counts and returns the signed result as a single-cycle strobe.

Each request goes through two chip-select frames. The first frame shifts the multiplexer address out. The clock then keeps running through the acquisition window and while the status line reports a conversion in progress. Chip select then stays high for a spacing interval. The second frame collects the result, least significant bit first with the sign bit last. A reset hold with chip select high follows before the next request is taken. The user supplies the address word as it is. A limit on the length of the conversion watch turns a stuck status line into an error strobe.

Top module: `sadc_host`

## Requirements
- R1: After reset, and whenever no exchange is running, `cs_n_o` is high, `sclk_o` is low, and `busy_o`, `res_vld_o` and `tmo_err_o` are low. `sclk_o` is never high while `cs_n_o` is high.
- R2: The high phase and the low phase of `sclk_o` each last `half_i` system cycles, with a value of 0 treated as 1. The first rising edge comes `half_i` cycles after `cs_n_o` falls.
- R3: The first frame gives exactly ADDR_W rising edges that carry `addr_i` on `di_o`, most significant bit first. `di_o` changes only while `sclk_o` is low.
- R4: After the address, ACQ_CYC (default 5) more rising edges cover acquisition. The clock then keeps running until a rising edge samples `sars_i` low. With a converter that is busy for 12 clocks starting after the acquisition window, the conversion frame holds 22 rising edges.
- R5: Between the end of the conversion frame and the start of the read frame, `cs_n_o` stays high for GAP_CYC (default 5) serial periods, which is 2·GAP_CYC·`half_i` system cycles.
- R6: The read frame gives 11 rising edges. `do_i` is sampled on each one, the first sample is bit 0 and the last is bit 10 (the sign), and `res_o` presents the word as an 11-bit two's-complement value.
- R7: `res_vld_o` pulses for exactly one cycle, in the cycle where `cs_n_o` rises after the read frame. `cs_n_o` then stays high for at least one serial period before `busy_o` falls.
- R8: A `start_i` pulse while `busy_o` is high is ignored. Only one address frame and one read frame occur, and both use the address that was accepted.
- R9: If `sars_i` is still high at the rising edge where the number of conversion-watch edges equals `tmo_i`, the controller pulses `tmo_err_o`, raises `cs_n_o`, skips the read frame and gives no `res_vld_o`. A status fall seen on that same edge wins over the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one address, convert and read sequence |
| addr_i | input | ADDR_W | Multiplexer address word, sent MSB first |
| half_i | input | DIV_W | Serial clock half period in system cycles |
| tmo_i | input | CNT_W | Limit on conversion-watch rising edges |
| sars_i | input | 1 | Converter busy status, high while converting |
| do_i | input | 1 | Serial result from the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| cs_n_o | output | 1 | Active-low chip select |
| di_o | output | 1 | Serial address to the converter |
| busy_o | output | 1 | Sequence in progress |
| res_o | output | RES_W | Last signed result |
| res_vld_o | output | 1 | One-cycle result strobe |
| tmo_err_o | output | 1 | One-cycle timeout strobe |

## Verification
Two events can land on the same rising edge: the status line falling, which ends the conversion, and the conversion-watch count reaching the timeout limit. The bench provokes this by setting `tmo_i` to exactly the count of watch edges that the converter model needs, 13. The status then drops on the same edge where the limit is reached. The correct outcome is a normal result strobe with no error and a complete read frame. Separately, a start request is injected in the middle of a frame to show that a request arriving during an exchange is dropped.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACQ,
    ST_CONV,
    ST_GAP,
    ST_READ,
    ST_RST
  } phase_t;

  // number of divider half-period ticks that make up a count of serial periods
  function automatic int ticks_for(input int periods);
    return 2 * periods;
  endfunction

  // phases in which the serial clock toggles
  function automatic logic clk_runs(input phase_t p);
    return (p == ST_ADDR) || (p == ST_ACQ) || (p == ST_CONV) || (p == ST_READ);
  endfunction

endpackage

// File: rtl/sadc_tick.sv
module sadc_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] half_cfg,
  output logic             half_tick
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  assign last      = (half_cfg == '0) ? '0 : half_cfg - 1'b1;
  assign half_tick = !restart && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (restart)    cnt <= '0;
    else if (cnt == last) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt <= last) || $past(restart) || $changed(half_cfg) || $past($changed(half_cfg)));

endmodule

// File: rtl/sadc_rx.sv
module sadc_rx #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word
);

  // a new bit enters at the top, so the first bit ends at position 0
  function automatic logic [W-1:0] lsb_first_push(input logic [W-1:0] w, input logic b);
    return {b, w[W-1:1]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (clr)      word <= '0;
    else if (shift_en) word <= lsb_first_push(word, bit_in);
  end

endmodule

// File: rtl/sadc_host.sv
module sadc_host
  import sadc_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int RES_W   = 11,
  parameter int DIV_W   = 16,
  parameter int CNT_W   = 8,
  parameter int ACQ_CYC = 5,
  parameter int GAP_CYC = 5,
  parameter int RST_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DIV_W-1:0]  half_i,
  input  logic [CNT_W-1:0]  tmo_i,
  input  logic              sars_i,
  input  logic              do_i,
  output logic              sclk_o,
  output logic              cs_n_o,
  output logic              di_o,
  output logic              busy_o,
  output logic [RES_W-1:0]  res_o,
  output logic              res_vld_o,
  output logic              tmo_err_o
);

  localparam logic [CNT_W-1:0] GAP_T  = CNT_W'(ticks_for(GAP_CYC) - 1);
  localparam logic [CNT_W-1:0] RST_T  = CNT_W'(ticks_for(RST_CYC) - 1);
  localparam logic [CNT_W-1:0] ADDR_N = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] ACQ_N  = CNT_W'(ACQ_CYC);
  localparam logic [CNT_W-1:0] RES_N  = CNT_W'(RES_W);

  phase_t            state;
  logic [CNT_W-1:0]  bcnt;
  logic [ADDR_W-1:0] addr_sh;
  logic              sars_s;
  logic              half_tick;
  logic              start_acc;
  logic              rise_evt;
  logic              fall_evt;
  logic              conv_done;
  logic              conv_tmo;
  logic [RES_W-1:0]  rx_word;

  assign start_acc = start_i && (state == ST_IDLE);
  assign rise_evt  = half_tick && clk_runs(state) && !sclk_o;
  assign fall_evt  = half_tick && clk_runs(state) && sclk_o;
  assign conv_done = fall_evt && (state == ST_CONV) && !sars_s;
  assign conv_tmo  = fall_evt && (state == ST_CONV) && sars_s && (bcnt == tmo_i);
  assign di_o      = addr_sh[ADDR_W-1];
  assign busy_o    = (state != ST_IDLE);

  sadc_tick #(.DIV_W(DIV_W)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (start_acc),
    .half_cfg  (half_i),
    .half_tick (half_tick)
  );

  sadc_rx #(.W(RES_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start_acc),
    .shift_en (rise_evt && (state == ST_READ)),
    .bit_in   (do_i),
    .word     (rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bcnt      <= '0;
      addr_sh   <= '0;
      sars_s    <= 1'b0;
      sclk_o    <= 1'b0;
      cs_n_o    <= 1'b1;
      res_o     <= '0;
      res_vld_o <= 1'b0;
      tmo_err_o <= 1'b0;
    end else begin
      res_vld_o <= 1'b0;
      tmo_err_o <= 1'b0;
      if (half_tick && clk_runs(state)) sclk_o <= !sclk_o;
      if (rise_evt) begin
        bcnt <= bcnt + 1'b1;
        if (state == ST_CONV) sars_s <= sars_i;
      end
      unique case (state)
        ST_IDLE: if (start_i) begin
          state   <= ST_ADDR;
          cs_n_o  <= 1'b0;
          addr_sh <= addr_i;
          bcnt    <= '0;
        end
        ST_ADDR: if (fall_evt) begin
          addr_sh <= addr_sh << 1;
          if (bcnt == ADDR_N) begin
            state <= ST_ACQ;
            bcnt  <= '0;
          end
        end
        ST_ACQ: if (fall_evt && bcnt == ACQ_N) begin
          state <= ST_CONV;
          bcnt  <= '0;
        end
        ST_CONV: if (conv_done) begin
          state  <= ST_GAP;
          cs_n_o <= 1'b1;
          bcnt   <= '0;
        end else if (conv_tmo) begin
          state     <= ST_RST;
          cs_n_o    <= 1'b1;
          tmo_err_o <= 1'b1;
          bcnt      <= '0;
        end
        ST_GAP: if (half_tick) begin
          if (bcnt == GAP_T) begin
            state  <= ST_READ;
            cs_n_o <= 1'b0;
            bcnt   <= '0;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        ST_READ: if (fall_evt && bcnt == RES_N) begin
          state     <= ST_RST;
          cs_n_o    <= 1'b1;
          res_o     <= rx_word;
          res_vld_o <= 1'b1;
          bcnt      <= '0;
        end
        ST_RST: if (half_tick) begin
          if (bcnt == RST_T) begin
            state <= ST_IDLE;
            bcnt  <= '0;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  sclk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);

  // R3
  di_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> $stable(di_o));

  // R7
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |=> !res_vld_o);

  // R7
  vld_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |-> ($rose(cs_n_o) && busy_o));

  // R9
  tmo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err_o |-> (!res_vld_o && cs_n_o));

  // R8
  cs_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> ($past(state) == ST_IDLE || $past(state) == ST_GAP));

endmodule

// File: tb/tb_sadc_host.sv
`timescale 1ns/1ps
module tb_sadc_host;

  localparam int AW = 4;
  localparam int RW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [15:0]   half_i = 16'd2;
  logic [7:0]    tmo_i = 8'd40;
  logic          sars_m = 1'b0;
  logic          do_m = 1'b0;
  logic          sclk, cs_n, di, busy, vld, terr;
  logic [RW-1:0] res;

  int n_chk = 0, n_bad = 0;
  int vld_cnt = 0, err_cnt = 0;
  logic [RW-1:0] res_seen = '0;

  // converter model state
  logic [AW-1:0] addr_rx = '0;
  logic [RW-1:0] val_m = '0;
  bit  stuck = 0;
  bit  rd_next = 0;
  int  frames = 0, conv_rises = 0, read_rises = 0;

  always #4 clk = ~clk;

  sadc_host dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .half_i(half_i), .tmo_i(tmo_i), .sars_i(sars_m), .do_i(do_m),
    .sclk_o(sclk), .cs_n_o(cs_n), .di_o(di), .busy_o(busy),
    .res_o(res), .res_vld_o(vld), .tmo_err_o(terr)
  );

  always @(negedge clk) begin
    if (vld)  begin vld_cnt++; res_seen = res; end
    if (terr) err_cnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_ge(input string req, input int act, input int lim);
    n_chk++;
    if (act < lim) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected >= %0d", req, act, lim);
    end
  endtask

  // ---------- converter model ----------
  task automatic conv_frame();
    int k = 0;
    bit fin = 0;
    while (!fin) begin
      @(posedge sclk or posedge cs_n); #1;
      if (cs_n) fin = 1;
      else begin
        k++;
        if (k <= AW) addr_rx = {addr_rx[AW-2:0], di};
        @(negedge sclk or posedge cs_n); #1;
        if (cs_n) fin = 1;
        else begin
          if (k == AW + 5) sars_m = 1'b1;
          if (k == AW + 5 + 12 && !stuck) sars_m = 1'b0;
        end
      end
    end
    conv_rises = k;
    rd_next = !sars_m;
    sars_m = 1'b0;
  endtask

  task automatic read_frame();
    int r = 0;
    bit fin = 0;
    do_m = val_m[0];
    while (!fin) begin
      @(posedge sclk or posedge cs_n); #1;
      if (cs_n) fin = 1;
      else begin
        r++;
        @(negedge sclk or posedge cs_n); #1;
        if (cs_n) fin = 1;
        else if (r < RW) do_m = val_m[r];
      end
    end
    read_rises = r;
    rd_next = 0;
  endtask

  initial begin
    forever begin
      @(negedge cs_n); #1;
      frames++;
      if (rd_next) read_frame();
      else conv_frame();
    end
  end

  // ---------- helpers ----------
  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic wait_cs(input logic lvl);
    while (cs_n !== lvl) @(negedge clk);
  endtask

  // one complete request with timing checks
  task automatic run_conv(input logic [AW-1:0] a, input logic [RW-1:0] v,
                          input int h, input int tmo, input bit inject);
    int hi, gap, hold, v0, e0, f0, heff;
    heff = (h == 0) ? 1 : h;
    v0 = vld_cnt; e0 = err_cnt; f0 = frames;
    val_m = v; stuck = 0;
    addr_i = a; half_i = 16'(h); tmo_i = 8'(tmo);
    pulse_start();
    wait_cs(1'b0);
    if (inject) begin
      addr_i = ~a;
      pulse_start();
    end
    while (!sclk) @(negedge clk);
    hi = 0;
    while (sclk) begin hi++; @(negedge clk); end
    check("R2 sclk high time", hi, heff);
    wait_cs(1'b1);
    gap = 0;
    while (cs_n) begin gap++; @(negedge clk); end
    check("R5 cs high spacing", gap, 10 * heff);
    check("R4 conversion frame rises", conv_rises, 22);
    check("R3 address received", int'(addr_rx), int'(a));
    wait_cs(1'b1);
    hold = 0;
    while (busy) begin hold++; @(negedge clk); end
    check_ge("R7 reset hold", hold, 2 * heff);
    check("R7 one valid strobe", vld_cnt - v0, 1);
    check("R6 result value", int'(res_seen), int'(v));
    check("R6 read frame rises", read_rises, RW);
    check("R9 no error", err_cnt - e0, 0);
    if (inject) check("R8 frames for one request", frames - f0, 2);
  endtask

  task automatic test_reset();
    check("R1 cs idle", int'(cs_n), 1);
    check("R1 sclk idle", int'(sclk), 0);
    check("R1 busy idle", int'(busy), 0);
    check("R1 no strobes", vld_cnt + err_cnt, 0);
  endtask

  task automatic test_timeout();
    int v0, e0, f0;
    v0 = vld_cnt; e0 = err_cnt; f0 = frames;
    stuck = 1; addr_i = 4'h3; half_i = 16'd2; tmo_i = 8'd8;
    pulse_start();
    wait_cs(1'b0);
    wait_cs(1'b1);
    while (busy) @(negedge clk);
    repeat (40) @(negedge clk);
    check("R9 error strobe", err_cnt - e0, 1);
    check("R9 no valid on timeout", vld_cnt - v0, 0);
    check("R9 rises before timeout", conv_rises, AW + 5 + 8);
    check("R9 no read frame", frames - f0, 1);
    check("R9 cs high after timeout", int'(cs_n), 1);
    stuck = 0;
  endtask

  task automatic test_ignore_idle();
    int f0;
    f0 = frames;
    repeat (60) @(negedge clk);
    check("R8 no extra frames", frames - f0, 0);
    check("R1 idle after run", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    run_conv(4'hA, 11'h7FB, 2, 40, 0);   // negative value, -5
    run_conv(4'h5, 11'h3FF, 3, 40, 0);   // largest positive
    run_conv(4'h9, 11'h401, 1, 40, 0);   // sign and LSB set: bit order
    run_conv(4'hC, 11'h155, 0, 40, 0);   // zero divider acts as one
    run_conv(4'h6, 11'h2AA, 2, 13, 0);   // status fall on the timeout edge
    run_conv(4'hE, 11'h000, 2, 40, 1);   // start during an exchange
    test_ignore_idle();
    test_timeout();
    run_conv(4'h1, 11'h401, 2, 40, 0);   // recovers after timeout
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule